// File: doc/BRIEF.md
# UART Interrupt Priority Resolver

This block decides which of a serial port's interrupt sources is reported, and whether the interrupt request line is raised. It takes the four-bit enable register, the receiver line status bits, the receive FIFO fill level with its trigger selection, a character-timeout flag and the modem-status change bits. It also keeps a hidden transmit-empty pending flag of its own. From these it produces a registered request output and a registered identification byte. The low nibble of that byte is a code for the winning source. The top two bits show whether the FIFOs are enabled.

The surrounding port logic drives strobes into the block. These strobes mark an enable-register write, an identification-register read, a load of the transmit holding register and the moment the holding register drains. The block owns the enable register and returns its value. The FIFO storage, the shifters and the baud timing all live outside it. A fixed order decides between sources that are active at the same time. Line errors come first, then the character timeout, then received data, then transmit-empty, then modem-status changes.

Top module: `uart_irq_resolver`

## Requirements
- R1: After reset the identification byte is 0x01, the request output is low and the enable register reads 0.
- R2: While the whole enable register is zero, the request output is low and the identification code is 0x1, even when the timeout flag or any status bit is active.
- R3: When enable bit 2 is set and any of line_stat bits 1 (overrun), 2 (parity), 3 (framing) or 4 (break) is set, the code is 0x6 and it outranks every other source.
- R4: When the enable register is nonzero, the character-timeout flag gives code 0xC, and it outranks received data and all lower sources. This source has no enable bit of its own.
- R5: Enable bit 0 with line_stat bit 0 (data ready) gives code 0x4. With FIFOs off, data ready alone is enough. With FIFOs on, rx_count must be at least the trigger level. trig_sel 00 selects 1, 01 selects DEPTH/4, 10 selects DEPTH/2 and 11 selects DEPTH-2.
- R6: When enable bit 0 and data ready are both set but the FIFO count is below the trigger level, no transmit-empty and no modem-status interrupt is reported. The code is 0x1.
- R7: Enable bit 1 with the pending flag set gives code 0x2. The flag is set by tx_empty_evt, or by an enable write while line_stat bit 5 (holding register empty) is set. It is cleared by iir_rd or thr_wr. If a set and a clear occur in the same cycle, the clear wins.
- R8: Enable bit 3 with any msr_delta bit set gives code 0x0, the lowest priority.
- R9: Identification bits 7:6 read 11 while fifo_on is high and 00 otherwise. Bits 5:4 always read 0.
- R10: An enable-register write keeps only the low four bits of ier_wdata. The kept value appears on ier_val.
- R11: irq and iir reflect the inputs and strobes present before a rising clock edge, and they update at that edge. irq is high exactly when the code is not 0x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Enable-register write strobe |
| ier_wdata | input | 8 | Enable-register write data |
| iir_rd | input | 1 | Identification-register read strobe |
| thr_wr | input | 1 | Transmit holding register load strobe |
| tx_empty_evt | input | 1 | Pulse when the holding register drains |
| line_stat | input | 6 | Line status: 0 ready, 1 overrun, 2 parity, 3 framing, 4 break, 5 holding empty |
| rx_tmo | input | 1 | Character-timeout pending flag |
| fifo_on | input | 1 | FIFOs enabled |
| trig_sel | input | 2 | Receive trigger level select |
| rx_count | input | CW | Receive FIFO fill count |
| msr_delta | input | 4 | Modem-status change bits |
| irq | output | 1 | Registered interrupt request |
| iir | output | 8 | Registered identification byte |
| ier_val | output | 4 | Current enable register |

## Verification
The bench builds the block with DEPTH at 16, so CW is 5. The four trigger levels are then 1, 4, 8 and 14, and rx_count can cover every value from empty up to a full FIFO of 16. This means each threshold can be tested exactly at its edge, one count below it, and at full. Random stimulus weights the line errors low, so the lower-priority sources also win often. This includes the masking case where received data sits below the trigger level. The strobe mix regularly puts a pending-flag set and a clear in the same cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // Identification codes; the values are decoded by software.
  typedef enum logic [3:0] {
    ID_MODEM  = 4'h0,
    ID_NONE   = 4'h1,
    ID_THRE   = 4'h2,
    ID_RXDATA = 4'h4,
    ID_LINE   = 4'h6,
    ID_TMO    = 4'hC
  } irq_id_e;

  // Line status bit positions.
  localparam int unsigned LS_READY      = 0;
  localparam int unsigned LS_ERR_LO     = 1;
  localparam int unsigned LS_ERR_HI     = 4;
  localparam int unsigned LS_HOLD_EMPTY = 5;

  // Enable register bit positions.
  localparam int unsigned EN_RXDATA = 0;
  localparam int unsigned EN_THRE   = 1;
  localparam int unsigned EN_LINE   = 2;
  localparam int unsigned EN_MODEM  = 3;

  typedef struct packed {
    logic line;      // enabled line error present
    logic tmo;       // character timeout
    logic rx_req;    // data ready with receive enable
    logic rx_ready;  // rx_req and the fill level reached
    logic thre;      // transmit-empty pending and enabled
    logic modem;     // modem change and enabled
  } src_t;

  // Receive trigger threshold for a given select code and FIFO depth.
  function automatic int unsigned trig_level(input logic [1:0] sel,
                                             input int unsigned depth);
    unique case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

  // True when the fill count satisfies the threshold.
  function automatic logic level_met(input int unsigned count,
                                     input logic [1:0] sel,
                                     input int unsigned depth);
    return count >= trig_level(sel, depth);
  endfunction

endpackage

// File: rtl/uart_irq_src.sv
module uart_irq_src
  import uart_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic [3:0]    ier,
  input  logic          pend,
  input  logic [4:0]    lstat,
  input  logic          tmo,
  input  logic          fifo_on,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] rx_count,
  input  logic [3:0]    msr_delta,
  output src_t          src
);

  logic any_err;
  logic fill_ok;

  assign any_err = |lstat[LS_ERR_HI:LS_ERR_LO];
  assign fill_ok = !fifo_on || level_met(32'(rx_count), trig_sel, DEPTH);

  always_comb begin
    src.line     = ier[EN_LINE] && any_err;
    src.tmo      = tmo;
    src.rx_req   = ier[EN_RXDATA] && lstat[LS_READY];
    src.rx_ready = ier[EN_RXDATA] && lstat[LS_READY] && fill_ok;
    src.thre     = ier[EN_THRE] && pend;
    src.modem    = ier[EN_MODEM] && (|msr_delta);
  end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic    ier_any,
  input  src_t    src,
  output irq_id_e code
);

  // Fixed order. A receive request that is below its level
  // ends the chain, so the lower sources stay hidden.
  always_comb begin
    code = ID_NONE;
    if (ier_any) begin
      if (src.line)        code = ID_LINE;
      else if (src.tmo)    code = ID_TMO;
      else if (src.rx_req) code = src.rx_ready ? ID_RXDATA : ID_NONE;
      else if (src.thre)   code = ID_THRE;
      else if (src.modem)  code = ID_MODEM;
    end
  end

endmodule

// File: rtl/uart_irq_pend.sv
module uart_irq_pend (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ier_wr,
  input  logic [7:0] ier_wdata,
  input  logic       iir_rd,
  input  logic       thr_wr,
  input  logic       tx_empty_evt,
  input  logic       hold_empty,
  output logic [3:0] ier_q,
  output logic [3:0] ier_nxt,
  output logic       pend_nxt,
  output logic       pend_set,
  output logic       pend_clr
);

  logic pend_q;
  logic unused_hi;

  assign unused_hi = ^ier_wdata[7:4];

  assign ier_nxt  = ier_wr ? ier_wdata[3:0] : ier_q;
  assign pend_set = tx_empty_evt || (ier_wr && hold_empty);
  assign pend_clr = iir_rd || thr_wr;

  always_comb begin
    pend_nxt = pend_q;
    if (pend_set) pend_nxt = 1'b1;
    if (pend_clr) pend_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q  <= 4'h0;
      pend_q <= 1'b0;
    end else begin
      ier_q  <= ier_nxt;
      pend_q <= pend_nxt;
    end
  end

endmodule

// File: rtl/uart_irq_resolver.sv
module uart_irq_resolver
  import uart_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ier_wr,
  input  logic [7:0]    ier_wdata,
  input  logic          iir_rd,
  input  logic          thr_wr,
  input  logic          tx_empty_evt,
  input  logic [5:0]    line_stat,
  input  logic          rx_tmo,
  input  logic          fifo_on,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] rx_count,
  input  logic [3:0]    msr_delta,
  output logic          irq,
  output logic [7:0]    iir,
  output logic [3:0]    ier_val
);

  logic [3:0] ier_nxt;
  logic       pend_nxt;
  logic       pend_set;
  logic       pend_clr;
  src_t       src;
  irq_id_e    code;
  logic [7:0] iir_q;
  logic       irq_q;

  uart_irq_pend u_pend (
    .clk          (clk),
    .rst_n        (rst_n),
    .ier_wr       (ier_wr),
    .ier_wdata    (ier_wdata),
    .iir_rd       (iir_rd),
    .thr_wr       (thr_wr),
    .tx_empty_evt (tx_empty_evt),
    .hold_empty   (line_stat[LS_HOLD_EMPTY]),
    .ier_q        (ier_val),
    .ier_nxt      (ier_nxt),
    .pend_nxt     (pend_nxt),
    .pend_set     (pend_set),
    .pend_clr     (pend_clr)
  );

  uart_irq_src #(.DEPTH(DEPTH)) u_src (
    .ier       (ier_nxt),
    .pend      (pend_nxt),
    .lstat     (line_stat[4:0]),
    .tmo       (rx_tmo),
    .fifo_on   (fifo_on),
    .trig_sel  (trig_sel),
    .rx_count  (rx_count),
    .msr_delta (msr_delta),
    .src       (src)
  );

  uart_irq_prio u_prio (
    .ier_any (|ier_nxt),
    .src     (src),
    .code    (code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iir_q <= {4'h0, ID_NONE};
      irq_q <= 1'b0;
    end else begin
      iir_q <= {fifo_on, fifo_on, 2'b00, code};
      irq_q <= (code != ID_NONE);
    end
  end

  assign iir = iir_q;
  assign irq = irq_q;

endmodule

// File: rtl/uart_irq_resolver_chk.sv
module uart_irq_resolver_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ier_wr,
  input logic [3:0] ier_wlow,
  input logic       iir_rd,
  input logic [3:0] line_err,
  input logic       rx_tmo,
  input logic       fifo_on,
  input logic       irq,
  input logic [7:0] iir,
  input logic [3:0] ier_val
);

  AST_ENABLE_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_val == 4'h0) |-> (!irq && iir[3:0] == 4'h1)); // R2

  AST_IER_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> (ier_val == $past(ier_wlow))); // R10

  AST_READ_DROPS_THRE: assert property (@(posedge clk) disable iff (!rst_n)
    iir_rd |=> (iir[3:0] != 4'h2)); // R7

  AST_LINE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ier_wr && ier_val[2] && (|line_err)) |=> (iir[3:0] == 4'h6)); // R3

  AST_TMO_OVER_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (!ier_wr && ier_val != 4'h0 && rx_tmo && !(ier_val[2] && (|line_err)))
    |=> (iir[3:0] == 4'hC)); // R4

  AST_FIFO_FLAG_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (iir[7:4] == {$past(fifo_on), $past(fifo_on), 2'b00})); // R9

endmodule

bind uart_irq_resolver uart_irq_resolver_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ier_wr   (ier_wr),
  .ier_wlow (ier_wdata[3:0]),
  .iir_rd   (iir_rd),
  .line_err (line_stat[4:1]),
  .rx_tmo   (rx_tmo),
  .fifo_on  (fifo_on),
  .irq      (irq),
  .iir      (iir),
  .ier_val  (ier_val)
);

// File: tb/uart_irq_resolver_test.sv
`timescale 1ns/1ps
module uart_irq_resolver_test;

  localparam int DEPTH = 16;
  localparam int CW    = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ier_wr = 1'b0;
  logic [7:0]    ier_wdata = 8'h00;
  logic          iir_rd = 1'b0;
  logic          thr_wr = 1'b0;
  logic          tx_empty_evt = 1'b0;
  logic [5:0]    line_stat = 6'h00;
  logic          rx_tmo = 1'b0;
  logic          fifo_on = 1'b0;
  logic [1:0]    trig_sel = 2'd0;
  logic [CW-1:0] rx_count = '0;
  logic [3:0]    msr_delta = 4'h0;
  logic          irq;
  logic [7:0]    iir;
  logic [3:0]    ier_val;

  always #5 clk = ~clk;

  uart_irq_resolver #(.DEPTH(DEPTH)) uut (
    .clk, .rst_n, .ier_wr, .ier_wdata, .iir_rd, .thr_wr, .tx_empty_evt,
    .line_stat, .rx_tmo, .fifo_on, .trig_sel, .rx_count, .msr_delta,
    .irq, .iir, .ier_val
  );

  int    vectors = 0;
  int    fails   = 0;
  bit    done    = 0;
  int    m_ier = 0, m_pend = 0, m_iir = 1, m_irq = 0;
  string m_tag = "R1";

  // Behavioural reference, advanced on every rising edge.
  always @(posedge clk) begin
    int nier, npend, code, lvl;
    if (!rst_n) begin
      m_ier = 0; m_pend = 0; m_iir = 1; m_irq = 0; m_tag = "R1";
    end else begin
      nier  = ier_wr ? (ier_wdata % 16) : m_ier;
      npend = m_pend;
      if (tx_empty_evt || (ier_wr && line_stat[5])) npend = 1;
      if (iir_rd || thr_wr) npend = 0;
      case (trig_sel)
        2'd0: lvl = 1;
        2'd1: lvl = 4;
        2'd2: lvl = 8;
        default: lvl = 14;
      endcase
      code = 1;
      m_tag = "R11";
      if (nier == 0) m_tag = "R2";
      else if ((nier & 4) != 0 && (line_stat & 6'h1E) != 0) begin code = 6; m_tag = "R3"; end
      else if (rx_tmo) begin code = 12; m_tag = "R4"; end
      else if ((nier & 1) != 0 && line_stat[0]) begin
        if (!fifo_on || rx_count >= lvl) begin code = 4; m_tag = "R5"; end
        else m_tag = "R6";
      end
      else if ((nier & 2) != 0 && npend != 0) begin code = 2; m_tag = "R7"; end
      else if ((nier & 8) != 0 && msr_delta != 0) begin code = 0; m_tag = "R8"; end
      m_iir  = (fifo_on ? 192 : 0) + code;
      m_irq  = (code != 1) ? 1 : 0;
      m_ier  = nier;
      m_pend = npend;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(m_tag, int'(iir[3:0]), m_iir % 16);
    chk("R9", int'(iir[7:4]), m_iir / 16);
    chk("R11", int'(irq), m_irq);
    chk("R10", int'(ier_val), m_ier);
  endtask

  task automatic quiet();
    ier_wr = 0; iir_rd = 0; thr_wr = 0; tx_empty_evt = 0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      quiet();
    end
  endtask

  task automatic wr_ier(input logic [7:0] v);
    ier_wr = 1; ier_wdata = v;
    cyc(1);
  endtask

  initial begin
    cyc(3);
    // R1: reset values
    chk("R1", int'(iir), 8'h01);
    chk("R1", int'(irq), 0);
    chk("R1", int'(ier_val), 0);
    rst_n = 1;
    cyc(2);

    // R2: timeout and errors with nothing enabled
    rx_tmo = 1; line_stat = 6'h1F; msr_delta = 4'hF;
    cyc(3);
    chk("R2", int'(irq), 0);

    // R10: upper bits dropped; R3 line status wins over everything
    wr_ier(8'hFF);
    cyc(2);
    chk("R10", int'(ier_val), 4'hF);
    chk("R3", int'(iir[3:0]), 4'h6);

    // R4: timeout over received data
    line_stat = 6'h01;
    cyc(2);
    chk("R4", int'(iir[3:0]), 4'hC);

    // R5 / R6: trigger levels with FIFOs on
    rx_tmo = 0; fifo_on = 1;
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      for (int c = 0; c <= DEPTH; c++) begin
        rx_count = CW'(c);
        cyc(1);
      end
    end
    trig_sel = 2'd3; rx_count = 5'd13;
    cyc(2);
    chk("R6", int'(iir[3:0]), 4'h1);
    rx_count = 5'd14;
    cyc(2);
    chk("R5", int'(iir[3:0]), 4'h4);
    chk("R9", int'(iir[7:6]), 2'b11);
    fifo_on = 0; rx_count = 0;
    cyc(2);
    chk("R5", int'(iir[3:0]), 4'h4);

    // R7: pending flag set by enable write with holding empty
    line_stat = 6'h20; msr_delta = 4'h1;
    wr_ier(8'h0A);
    cyc(1);
    chk("R7", int'(iir[3:0]), 4'h2);
    iir_rd = 1;
    cyc(2);
    chk("R8", int'(iir[3:0]), 4'h0);
    tx_empty_evt = 1; thr_wr = 1;
    cyc(2);
    chk("R7", int'(iir[3:0]), 4'h0);
    tx_empty_evt = 1;
    cyc(2);
    chk("R7", int'(iir[3:0]), 4'h2);

    // Random mix
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      compare_all();
      ier_wr       = ($urandom % 8) == 0;
      ier_wdata    = 8'($urandom);
      iir_rd       = ($urandom % 6) == 0;
      thr_wr       = ($urandom % 10) == 0;
      tx_empty_evt = ($urandom % 7) == 0;
      line_stat    = {1'($urandom), (($urandom % 12) == 0) ? 4'($urandom) : 4'h0,
                      1'($urandom)};
      rx_tmo       = ($urandom % 8) == 0;
      if ((k % 200) == 0) fifo_on = 1'($urandom);
      trig_sel     = 2'($urandom);
      rx_count     = CW'($urandom % (DEPTH + 1));
      msr_delta    = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
    end
    cyc(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule